// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a pointer-tagging memory-safety scheme and inserts it into a 64-bit pointer. In its generate mode it holds a 24-bit state word. The low nibble of that word is the previous tag and bits 23:8 are a 16-bit pseudo-random seed. Four LFSR steps on the seed yield a 4-bit offset. The block then walks the tag space from the previous tag and counts only the tags that are not excluded. The resulting pointer is returned and the state word is rewritten.

In its adjust mode the block uses the pointer's own tag as the start tag and a 4-bit immediate as the offset. It adds a signed address displacement to the pointer and leaves the state word untouched. The exclusion mask comes from a control word. In generate mode an instruction operand mask is ORed into it. When a control bit allows random seeding and the seed is zero, a replacement seed is taken from an input port. The tag walk is iterative, one tag step per clock, and finishes with a one-cycle done pulse.

Top module: `alloc_tag_gen`

## Requirements
- R1: After reset, state_o, ptr_o, busy_o and done_o are all zero.
- R2: When the block is idle and start_i is low, state_ld_i writes state_ld_data_i into the state word. A load while busy_o is high has no effect.
- R3: In generate mode the exclusion mask is excl_op_i | ctrl_i[15:0]. In adjust mode it is ctrl_i[15:0] alone. Bit n set forbids tag n.
- R4: If all 16 tags are excluded, the chosen tag is 0.
- R5: One seed step computes fb = s[5]^s[3]^s[2]^s[0] and the new seed {fb, s[15:1]}. Generate mode applies four steps, and the fb of step i (i = 0..3) becomes bit i of the offset.
- R6: With offset 0, the tag is the start tag, advanced by one (mod 16) for as long as the current tag is excluded.
- R7: With offset k > 0, the tag moves to the next non-excluded tag (mod 16), and this is done k times.
- R8: ptr_o carries the tag in bits 59:56. Its other bits equal ptr_i in generate mode, or ptr_i plus the sign-extended addr_off_i in adjust mode (mode_i = 1).
- R9: Generate mode (mode_i = 0) rewrites the state as {new seed, 4'b0000, tag}, with the start tag read from state bits 3:0. Adjust mode leaves the state unchanged and takes its start tag from ptr_i[59:56] and its offset from tag_off_i.
- R10: If ctrl_i[16] is 1 and the seed is zero, the block samples reseed_i once per cycle for up to RESEED_TRIES cycles and takes the first nonzero value. If every sample is zero, it uses 1. With ctrl_i[16] at 0, a zero seed is kept.
- R11: start_i is ignored while busy_o is high. done_o is a single-cycle pulse, and an operation never stays busy longer than RESEED_TRIES + 260 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_ld_i | input | 1 | Load the state word (idle only) |
| state_ld_data_i | input | 24 | Value to load into the state word |
| start_i | input | 1 | Begin an operation |
| mode_i | input | 1 | 0 = generate, 1 = adjust |
| ptr_i | input | 64 | Source pointer |
| excl_op_i | input | 16 | Operand exclusion mask (generate mode) |
| ctrl_i | input | 17 | [15:0] exclusion mask, [16] random seeding allowed |
| addr_off_i | input | OFF_W | Signed address displacement (adjust mode) |
| tag_off_i | input | 4 | Tag offset (adjust mode) |
| reseed_i | input | 16 | Replacement seed source |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 64 | Result pointer |
| state_o | output | 24 | Current state word |

## Verification
Adjust mode is swept over every start tag and every tag offset under four masks. The all-clear mask isolates plain modular counting. The alternating mask shows that skipped tags are not counted. A mask with only tags 0 and 15 allowed forces wrap-around across many full rotations, and the all-set mask exercises the zero fallback. Generate mode runs a chain of operations whose state carries from one operation to the next, with operand and control masks that vary independently, so a wrong OR of the masks, a wrong tap or a wrong offset bit order breaks the chain. Dedicated cases cover zero-seed reseeding from a nonzero source, the fallback to 1, a zero seed with random seeding disabled, and start or load pulses arriving while busy.

// File: rtl/atg_pkg.sv
package atg_pkg;
  localparam int TAG_W    = 4;
  localparam int NTAG     = 1 << TAG_W;
  localparam int SEED_W   = 16;
  localparam int SEED_LSB = 8;
  localparam int STATE_W  = SEED_LSB + SEED_W;
  localparam int LFSR_STEPS = TAG_W;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RESEED = 2'd1,
    S_PREP   = 2'd2,
    S_WALK   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/atg_lfsr.sv
module atg_lfsr #(
  parameter int SW    = 16,
  parameter int STEPS = 4
) (
  input  logic [SW-1:0]    seed_i,
  output logic [SW-1:0]    seed_o,
  output logic [STEPS-1:0] off_o
);
  logic [SW-1:0] chain [0:STEPS];

  assign chain[0] = seed_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb           = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
    assign chain[g+1]   = {fb, chain[g][SW-1:1]};
    assign off_o[g]     = fb;
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/atg_walker.sv
module atg_walker #(
  parameter int TW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [TW-1:0]       start_tag_i,
  input  logic [TW-1:0]       off_i,
  input  logic [(1<<TW)-1:0]  excl_i,
  output logic                done_o,
  output logic [TW-1:0]       tag_o
);
  localparam int NT = 1 << TW;

  logic          run_q, run_d;
  logic          allex_q, allex_d;
  logic [TW-1:0] cur_q, cur_d;
  logic [TW-1:0] rem_q, rem_d;
  logic [NT-1:0] excl_q, excl_d;
  logic          done_q, done_d;
  logic [TW-1:0] tag_q, tag_d;
  logic [TW-1:0] nxt;

  assign nxt = cur_q + 1'b1;

  always_comb begin
    run_d   = run_q;
    allex_d = allex_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    excl_d  = excl_q;
    tag_d   = tag_q;
    done_d  = 1'b0;
    if (go_i) begin
      run_d   = 1'b1;
      cur_d   = start_tag_i;
      rem_d   = off_i;
      excl_d  = excl_i;
      allex_d = &excl_i;
    end else if (run_q) begin
      if (allex_q) begin
        tag_d  = '0;
        done_d = 1'b1;
        run_d  = 1'b0;
      end else if (rem_q == '0) begin
        if (excl_q[cur_q]) begin
          cur_d = nxt;
        end else begin
          tag_d  = cur_q;
          done_d = 1'b1;
          run_d  = 1'b0;
        end
      end else begin
        cur_d = nxt;
        if (!excl_q[nxt]) begin
          if (rem_q == TW'(1)) begin
            tag_d  = nxt;
            done_d = 1'b1;
            run_d  = 1'b0;
          end else begin
            rem_d = rem_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      allex_q <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      excl_q  <= '0;
      done_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      run_q   <= run_d;
      allex_q <= allex_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      excl_q  <= excl_d;
      done_q  <= done_d;
      tag_q   <= tag_d;
    end
  end

  assign done_o = done_q;
  assign tag_o  = tag_q;

  AST_TAG_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !allex_q) |-> !excl_q[tag_q]);  // R7
  AST_ALLEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && allex_q) |-> (tag_q == '0));  // R4
  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !go_i && !allex_q && run_d) |=> (cur_q == $past(nxt)));  // R6
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen
  import atg_pkg::*;
#(
  parameter int PTR_W        = 64,
  parameter int TAG_LSB      = 56,
  parameter int OFF_W        = 12,
  parameter int RESEED_TRIES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                state_ld_i,
  input  logic [23:0]         state_ld_data_i,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic [15:0]         excl_op_i,
  input  logic [16:0]         ctrl_i,
  input  logic [OFF_W-1:0]    addr_off_i,
  input  logic [3:0]          tag_off_i,
  input  logic [15:0]         reseed_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [PTR_W-1:0]    ptr_o,
  output logic [23:0]         state_o
);
  localparam int TRY_W    = (RESEED_TRIES > 1) ? $clog2(RESEED_TRIES) : 1;
  localparam int BUSY_MAX = RESEED_TRIES + NTAG * NTAG + 4;
  localparam int BCNT_W   = $clog2(BUSY_MAX + 2);

  ctl_state_e          st_q, st_d;
  logic                mode_q, mode_d;
  logic                rnd_q, rnd_d;
  logic [PTR_W-1:0]    base_q, base_d;
  logic [NTAG-1:0]     excl_q, excl_d;
  logic [TAG_W-1:0]    stag_q, stag_d;
  logic [TAG_W-1:0]    off_q, off_d;
  logic [SEED_W-1:0]   seed_q, seed_d;
  logic [SEED_W-1:0]   nseed_q, nseed_d;
  logic [TRY_W-1:0]    try_q, try_d;
  logic [STATE_W-1:0]  state_q, state_d;
  logic [PTR_W-1:0]    res_q, res_d;
  logic                done_q, done_d;
  logic                go_q, go_d;
  logic [BCNT_W-1:0]   bcnt_q;

  logic [SEED_W-1:0]   lfsr_seed;
  logic [TAG_W-1:0]    lfsr_off;
  logic                walk_done;
  logic [TAG_W-1:0]    walk_tag;
  logic [PTR_W-1:0]    sum_ptr;

  atg_lfsr #(.SW(SEED_W), .STEPS(LFSR_STEPS)) u_lfsr (
    .seed_i (seed_q),
    .seed_o (lfsr_seed),
    .off_o  (lfsr_off)
  );

  atg_walker #(.TW(TAG_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go_q),
    .start_tag_i (stag_q),
    .off_i       (off_q),
    .excl_i      (excl_q),
    .done_o      (walk_done),
    .tag_o       (walk_tag)
  );

  assign sum_ptr = ptr_i + {{(PTR_W-OFF_W){addr_off_i[OFF_W-1]}}, addr_off_i};

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    rnd_d   = rnd_q;
    base_d  = base_q;
    excl_d  = excl_q;
    stag_d  = stag_q;
    off_d   = off_q;
    seed_d  = seed_q;
    nseed_d = nseed_q;
    try_d   = try_q;
    state_d = state_q;
    res_d   = res_q;
    done_d  = 1'b0;
    go_d    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          mode_d = mode_i;
          rnd_d  = ctrl_i[16];
          if (mode_i) begin
            excl_d = ctrl_i[15:0];
            base_d = sum_ptr;
            stag_d = ptr_i[TAG_LSB +: TAG_W];
            off_d  = tag_off_i;
            go_d   = 1'b1;
            st_d   = S_WALK;
          end else begin
            excl_d = excl_op_i | ctrl_i[15:0];
            base_d = ptr_i;
            stag_d = state_q[TAG_W-1:0];
            seed_d = state_q[SEED_LSB +: SEED_W];
            try_d  = '0;
            if (ctrl_i[16] && (state_q[SEED_LSB +: SEED_W] == '0)) begin
              st_d = S_RESEED;
            end else begin
              st_d = S_PREP;
            end
          end
        end else if (state_ld_i) begin
          state_d = state_ld_data_i;
        end
      end
      S_RESEED: begin
        if (reseed_i != '0) begin
          seed_d = reseed_i;
          st_d   = S_PREP;
        end else if (try_q == TRY_W'(RESEED_TRIES - 1)) begin
          seed_d = SEED_W'(1);
          st_d   = S_PREP;
        end else begin
          try_d = try_q + 1'b1;
        end
      end
      S_PREP: begin
        off_d   = lfsr_off;
        nseed_d = lfsr_seed;
        go_d    = 1'b1;
        st_d    = S_WALK;
      end
      S_WALK: begin
        if (walk_done) begin
          res_d = base_q;
          res_d[TAG_LSB +: TAG_W] = walk_tag;
          if (!mode_q) begin
            state_d = {nseed_q, {(SEED_LSB-TAG_W){1'b0}}, walk_tag};
          end
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      mode_q  <= 1'b0;
      rnd_q   <= 1'b0;
      base_q  <= '0;
      excl_q  <= '0;
      stag_q  <= '0;
      off_q   <= '0;
      seed_q  <= '0;
      nseed_q <= '0;
      try_q   <= '0;
      state_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      rnd_q   <= rnd_d;
      base_q  <= base_d;
      excl_q  <= excl_d;
      stag_q  <= stag_d;
      off_q   <= off_d;
      seed_q  <= seed_d;
      nseed_q <= nseed_d;
      try_q   <= try_d;
      state_q <= state_d;
      res_q   <= res_d;
      done_q  <= done_d;
      go_q    <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (st_q == S_IDLE) begin
      bcnt_q <= '0;
    end else if (bcnt_q != '1) begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign ptr_o   = res_q;
  assign state_o = state_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R11
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BCNT_W'(BUSY_MAX));  // R11
  AST_ADJ_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WALK && walk_done && mode_q) |=> $stable(state_q));  // R9
  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PREP && rnd_q) |-> (seed_q != '0));  // R10
  AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(st_q == S_WALK && walk_done)) |=> $stable(state_q));  // R2
endmodule

// File: tb/sim_alloc_tag_gen.sv
`timescale 1ns/1ps
module sim_alloc_tag_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        state_ld_i = 1'b0;
  logic [23:0] state_ld_data_i = '0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [63:0] ptr_i = '0;
  logic [15:0] excl_op_i = '0;
  logic [16:0] ctrl_i = '0;
  logic [11:0] addr_off_i = '0;
  logic [3:0]  tag_off_i = '0;
  logic [15:0] reseed_i = '0;
  logic        busy_o, done_o;
  logic [63:0] ptr_o;
  logic [23:0] state_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  alloc_tag_gen u0 (
    .clk(clk), .rst_n(rst_n), .state_ld_i(state_ld_i), .state_ld_data_i(state_ld_data_i),
    .start_i(start_i), .mode_i(mode_i), .ptr_i(ptr_i), .excl_op_i(excl_op_i),
    .ctrl_i(ctrl_i), .addr_off_i(addr_off_i), .tag_off_i(tag_off_i), .reseed_i(reseed_i),
    .busy_o(busy_o), .done_o(done_o), .ptr_o(ptr_o), .state_o(state_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_walk(input logic [3:0] st, input logic [3:0] off,
                                        input logic [15:0] ex);
    logic [3:0] t;
    t = st;
    if (ex == 16'hFFFF) return 4'd0;
    if (off == 0) begin
      while (ex[t]) t = t + 1'b1;
    end else begin
      for (int k = 0; k < off; k++) begin
        t = t + 1'b1;
        while (ex[t]) t = t + 1'b1;
      end
    end
    return t;
  endfunction

  function automatic logic [19:0] m_lfsr(input logic [15:0] s);
    logic [15:0] x;
    logic [3:0]  o;
    logic        fb;
    x = s;
    for (int k = 0; k < 4; k++) begin
      fb = x[5] ^ x[3] ^ x[2] ^ x[0];
      x = {fb, x[15:1]};
      o[k] = fb;
    end
    return {x, o};
  endfunction

  function automatic logic [63:0] ins(input logic [63:0] p, input logic [3:0] t);
    return {p[63:60], t, p[55:0]};
  endfunction

  task automatic run_op(input logic md, input logic [63:0] p, input logic [15:0] eo,
                        input logic [16:0] c, input logic [11:0] ao, input logic [3:0] to,
                        input logic [15:0] rs);
    int n;
    @(negedge clk);
    mode_i = md; ptr_i = p; excl_op_i = eo; ctrl_i = c; addr_off_i = ao;
    tag_off_i = to; reseed_i = rs; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 600) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) chk("R11 done timeout", 64'd0, 64'd1);
  endtask

  task automatic load_state(input logic [23:0] v);
    @(negedge clk);
    state_ld_i = 1'b1; state_ld_data_i = v;
    @(negedge clk);
    state_ld_i = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        fails++;
        $display("FAIL R11 watchdog actual=%0d expected<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [23:0] ms;
    logic [15:0] sd;
    logic [19:0] lr;
    logic [3:0]  tg;
    logic [63:0] ep;
    logic [15:0] masks [4];
    masks[0] = 16'h0000; masks[1] = 16'h5555; masks[2] = 16'h7FFE; masks[3] = 16'hFFFF;

    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", {40'd0, state_o}, 64'd0);
    chk("R1 ptr", ptr_o, 64'd0);
    chk("R1 busy/done", {62'd0, busy_o, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load
    load_state(24'hACE105);
    chk("R2 load", {40'd0, state_o}, 64'h0000_0000_00AC_E105);

    // R3 R4 R6 R7 R8 R9 adjust-mode sweep
    for (int mi = 0; mi < 4; mi++) begin
      for (int st = 0; st < 16; st++) begin
        for (int of = 0; of < 16; of++) begin
          logic [63:0] p;
          logic [11:0] ao;
          p  = 64'h1234_5678_9ABC_DEF0 ^ (64'(st) << 56) ^ (64'(of * 977) << 4);
          ao = 12'(of * 301 - 2000);
          run_op(1'b1, p, 16'hFFFF, {1'b0, masks[mi]}, ao, 4'(of), 16'h0);
          tg = m_walk(p[59:56], 4'(of), masks[mi]);
          ep = ins(p + {{52{ao[11]}}, ao}, tg);
          chk(masks[mi] == 16'hFFFF ? "R4 all excluded" : (of == 0 ? "R6 adjust" : "R7/R8 adjust"),
              ptr_o, ep);
        end
      end
    end
    chk("R9 adjust keeps state", {40'd0, state_o}, 64'h0000_0000_00AC_E105);

    // R3 R5 R7 R9 generate chain
    ms = 24'hACE105;
    for (int i = 0; i < 48; i++) begin
      logic [15:0] eo;
      logic [15:0] ce;
      logic [63:0] p;
      eo = 16'(i * 16'h1357) & 16'h0F0F;
      ce = 16'(i * 16'h2468) & 16'hF0F0;
      p  = {8'hA5, 56'(i * 64'h0123_4567_89AB)};
      run_op(1'b0, p, eo, {1'b0, ce}, 12'h0, 4'h0, 16'h0);
      lr = m_lfsr(ms[23:8]);
      tg = m_walk(ms[3:0], lr[3:0], eo | ce);
      ms = {lr[19:4], 4'h0, tg};
      chk("R3/R5/R8 generate ptr", ptr_o, ins(p, tg));
      chk("R5/R9 generate state", {40'd0, state_o}, {40'd0, ms});
    end

    // R10 zero seed, random allowed, nonzero source
    load_state(24'h00000B);
    run_op(1'b0, 64'h0, 16'h0, 17'h1_0000, 12'h0, 4'h0, 16'h1234);
    lr = m_lfsr(16'h1234);
    tg = m_walk(4'hB, lr[3:0], 16'h0);
    chk("R10 reseed source", {40'd0, state_o}, {40'd0, lr[19:4], 4'h0, tg});
    // R10 fallback to 1
    load_state(24'h000003);
    run_op(1'b0, 64'h0, 16'h0, 17'h1_0000, 12'h0, 4'h0, 16'h0);
    lr = m_lfsr(16'h0001);
    tg = m_walk(4'h3, lr[3:0], 16'h0);
    chk("R10 reseed fallback", {40'd0, state_o}, {40'd0, lr[19:4], 4'h0, tg});
    // R10 zero seed kept when not allowed
    load_state(24'h000007);
    run_op(1'b0, 64'h0, 16'h0180, 17'h0_0000, 12'h0, 4'h0, 16'h5555);
    chk("R10 zero seed kept", {40'd0, state_o}, 64'h9);

    // R11 R2 start and load while busy ignored
    load_state(24'h5A5A02);
    @(negedge clk);
    mode_i = 1'b0; ptr_i = 64'h0F00_0000_0000_1000; excl_op_i = 16'h0; ctrl_i = 17'h0;
    start_i = 1'b1;
    @(negedge clk);
    ptr_i = 64'hFFFF_FFFF_FFFF_FFFF; excl_op_i = 16'hFFFF;
    state_ld_i = 1'b1; state_ld_data_i = 24'h111111;
    chk("R11 busy", {63'd0, busy_o}, 64'd1);
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0; state_ld_i = 1'b0;
    begin
      int n;
      n = 0;
      while (!done_o && n < 600) begin @(negedge clk); n++; end
    end
    lr = m_lfsr(16'h5A5A);
    tg = m_walk(4'h2, lr[3:0], 16'h0);
    chk("R11 start ignored", ptr_o, ins(64'h0F00_0000_0000_1000, tg));
    chk("R2 load ignored busy", {40'd0, state_o}, {40'd0, lr[19:4], 4'h0, tg});
    @(negedge clk);
    chk("R11 done pulse", {63'd0, done_o}, 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule